// File: doc/BRIEF.md
# Host Controller Clock Gating Controller

This block decides, on every cycle, which of three clocks of a card host controller may run: the card-side interface clock, the system clock and the bus clock. It watches the events that need a clock: command activity, path resets, divisor changes, continue requests, card presence and card interrupts, data transfers and the card initialization phase. From these it produces one registered enable per clock domain. The gate cells that consume these enables, and the register bus that supplies the override bits, are outside the block.

Each domain has a force-on override. The three domains are woken by different sets of events. They are also chained: the bus clock is never gated while the card clock runs. The bus clock has a second force-on source, the peripheral override. Clearing the bus override therefore lets the bus clock gate only when the peripheral override is clear as well. A built-in down-counter times the card initialization phase. Single-cycle events are stretched so that a gate cannot close in the cycle right after the event that needed it.

Top module: `host_clk_gate`

## Requirements
- R1: While reset is asserted, all three enables are 1. With every input at 0, all three enables are 0 after the first clock edge that follows the release of reset.
- R2: When the card override is 1 at a clock edge, the card enable and the bus enable are 1 after that edge.
- R3: After each edge, the system enable equals the OR of the system override and the data-transfer-active input as they were sampled at that edge. No other input affects it.
- R4: Each of the level wake inputs, taken alone, sets the card enable to 1 after the edge at which it is sampled high: command-path reset, data-path reset, soft reset, card inserted, card removed and card interrupt.
- R5: A single-cycle pulse on command-send, divisor-updated or continue-request keeps the card enable at 1 for exactly two cycles after the edge that samples it. The enable returns to 0 on the third edge if nothing else holds it.
- R6: The bus enable is woken on its own by card inserted, card removed and card interrupt. A continue-request pulse holds it for the same two cycles as the card enable.
- R7: The bus enable is 1 in every cycle in which the card enable is 1.
- R8: The bus enable is forced to 1 when the bus override or the peripheral override is 1. It can be gated automatically only when both are 0.
- R9: An init-start pulse sampled while the phase counter is idle loads it with 80. The counter counts down once per cycle while the card enable is 1. The card enable stays 1 from the start edge through 80 further edges, 81 sampled cycles in all, and is 0 after the next edge.
- R10: An init-start pulse sampled while the phase counter is non-zero is ignored. The card enable still falls at the deadline set by the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ovr_card_i | input | 1 | Force the card-side clock on |
| ovr_sys_i | input | 1 | Force the system clock on |
| ovr_bus_i | input | 1 | Force the bus clock on |
| ovr_periph_i | input | 1 | Peripheral override; while set, the bus clock stays on |
| ev_cmd_send_i | input | 1 | Pulse: a command is about to be sent |
| ev_div_upd_i | input | 1 | Pulse: clock divisor was just updated |
| ev_cont_req_i | input | 1 | Pulse: continue request was just set |
| rst_cmd_i | input | 1 | Level: command path in reset |
| rst_dat_i | input | 1 | Level: data path in reset |
| rst_all_i | input | 1 | Level: soft reset active |
| card_ins_i | input | 1 | Level: card insertion detected |
| card_rem_i | input | 1 | Level: card removal detected |
| card_irq_i | input | 1 | Level: card interrupt detected |
| init_start_i | input | 1 | Pulse: start the 80-cycle initialization phase |
| xfer_active_i | input | 1 | Level: data transfer active on the card bus |
| en_card_o | output | 1 | Registered card-side clock enable |
| en_sys_o | output | 1 | Registered system clock enable |
| en_bus_o | output | 1 | Registered bus clock enable |

## Verification
Two functions can meet in one cycle: an init-start request can arrive while the phase counter is still running, and a continue request can wake the card and bus domains at the same edge. The bench raises init-start a second time in the middle of a running phase. It judges the result by the cycle in which the card enable falls, which must be the deadline of the first start and not a restarted one. The continue-request pulse is judged on both enables together. Both must rise and fall on the same edges, so the bus never closes while the card clock runs.

// File: rtl/hcg_pkg.sv
package hcg_pkg;

    // Registered enable set, one bit per clock domain
    typedef struct packed {
        logic card;
        logic sys;
        logic bus;
    } gate_en_t;

    // Indices of the single-cycle events that get stretched
    localparam int PULSE_CMD  = 0;
    localparam int PULSE_DIV  = 1;
    localparam int PULSE_CONT = 2;
    localparam int NUM_PULSE  = 3;

endpackage

// File: rtl/hcg_pulse_hold.sv
module hcg_pulse_hold #(
    parameter int HOLD = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ev_i,
    output logic active_o
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HOLD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ev_i) begin
            cnt_d = RELOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Wake is live in the event cycle and while the stretch remains
    assign active_o = ev_i | (cnt_q != '0);

    // R5: the cycle after an event still requests the clock
    p_hold_after_event_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_i && HOLD > 1) |=> active_o);

endmodule

// File: rtl/hcg_init_timer.sv
module hcg_init_timer #(
    parameter int INIT_CYCLES = 80
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic dec_en_i,
    output logic busy_o
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(INIT_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q == '0) begin
            if (start_i) begin
                cnt_d = LOAD;
            end
        end else if (dec_en_i) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

    // R9: the phase count never exceeds its programmed length
    p_count_bounded_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LOAD);

    // R10: a start during a running phase does not reload the counter
    p_no_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0 && start_i && dec_en_i) |=> cnt_q == CW'($past(cnt_q) - 1'b1));

    // R9: an idle start always loads the full length
    p_load_on_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == '0 && start_i) |=> cnt_q == LOAD);

endmodule

// File: rtl/host_clk_gate.sv
module host_clk_gate #(
    parameter int INIT_CYCLES = 80,
    parameter int PULSE_HOLD  = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ovr_card_i,
    input  logic ovr_sys_i,
    input  logic ovr_bus_i,
    input  logic ovr_periph_i,
    input  logic ev_cmd_send_i,
    input  logic ev_div_upd_i,
    input  logic ev_cont_req_i,
    input  logic rst_cmd_i,
    input  logic rst_dat_i,
    input  logic rst_all_i,
    input  logic card_ins_i,
    input  logic card_rem_i,
    input  logic card_irq_i,
    input  logic init_start_i,
    input  logic xfer_active_i,
    output logic en_card_o,
    output logic en_sys_o,
    output logic en_bus_o
);
    import hcg_pkg::*;

    gate_en_t gate_d, gate_q;

    logic [NUM_PULSE-1:0] pulse_ev;
    logic [NUM_PULSE-1:0] pulse_act;
    logic                 init_busy;
    logic                 card_evt;
    logic                 bus_force;

    always_comb begin
        pulse_ev             = '0;
        pulse_ev[PULSE_CMD]  = ev_cmd_send_i;
        pulse_ev[PULSE_DIV]  = ev_div_upd_i;
        pulse_ev[PULSE_CONT] = ev_cont_req_i;
    end

    // One stretcher per single-cycle event
    for (genvar i = 0; i < NUM_PULSE; i++) begin : g_hold
        hcg_pulse_hold #(
            .HOLD (PULSE_HOLD)
        ) u_hold (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .ev_i     (pulse_ev[i]),
            .active_o (pulse_act[i])
        );
    end

    // Phase counter only advances on cycles the card clock actually runs
    hcg_init_timer #(
        .INIT_CYCLES (INIT_CYCLES)
    ) u_init (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (init_start_i),
        .dec_en_i (gate_q.card),
        .busy_o   (init_busy)
    );

    always_comb begin
        card_evt  = card_ins_i | card_rem_i | card_irq_i;
        // Peripheral override keeps the bus clock up regardless of its own bit
        bus_force = ovr_bus_i | ovr_periph_i;

        gate_d.card = ovr_card_i
                    | init_busy | init_start_i
                    | rst_cmd_i | rst_dat_i | rst_all_i
                    | pulse_act[PULSE_CMD]
                    | pulse_act[PULSE_DIV]
                    | pulse_act[PULSE_CONT]
                    | card_evt;

        gate_d.sys  = ovr_sys_i | xfer_active_i;

        // Chain: bus follows the card domain's next state
        gate_d.bus  = bus_force
                    | pulse_act[PULSE_CONT]
                    | card_evt
                    | gate_d.card;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q <= '1;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign en_card_o = gate_q.card;
    assign en_sys_o  = gate_q.sys;
    assign en_bus_o  = gate_q.bus;

    // R7: bus clock never gated while the card clock runs
    p_bus_under_card_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_card_o |-> en_bus_o);

    // R8: peripheral override alone holds the bus clock
    p_periph_holds_bus_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_periph_i |=> en_bus_o);

    // R2: card override forces the card clock
    p_card_override_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_card_i |=> en_card_o);

    // R3: system clock closes with no transfer and no override
    p_sys_idle_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ovr_sys_i && !xfer_active_i) |=> !en_sys_o);

    // R9: running phase keeps the card clock up
    p_init_keeps_card_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_busy |=> en_card_o);

endmodule

// File: tb/host_clk_gate_bench.sv
module host_clk_gate_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovr_card = 0, ovr_sys = 0, ovr_bus = 0, ovr_periph = 0;
    logic ev_cmd = 0, ev_div = 0, ev_cont = 0;
    logic r_cmd = 0, r_dat = 0, r_all = 0;
    logic c_ins = 0, c_rem = 0, c_irq = 0;
    logic init_start = 0, xfer = 0;
    logic en_card, en_sys, en_bus;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    host_clk_gate u_host_clk_gate (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .ovr_card_i    (ovr_card),
        .ovr_sys_i     (ovr_sys),
        .ovr_bus_i     (ovr_bus),
        .ovr_periph_i  (ovr_periph),
        .ev_cmd_send_i (ev_cmd),
        .ev_div_upd_i  (ev_div),
        .ev_cont_req_i (ev_cont),
        .rst_cmd_i     (r_cmd),
        .rst_dat_i     (r_dat),
        .rst_all_i     (r_all),
        .card_ins_i    (c_ins),
        .card_rem_i    (c_rem),
        .card_irq_i    (c_irq),
        .init_start_i  (init_start),
        .xfer_active_i (xfer),
        .en_card_o     (en_card),
        .en_sys_o      (en_sys),
        .en_bus_o      (en_bus)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Inputs change at the falling edge; one tick = next rising edge, then sample
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_all(input string tag, input logic c, input logic s, input logic b);
        chk({tag, " card"}, en_card, c);
        chk({tag, " sys"},  en_sys,  s);
        chk({tag, " bus"},  en_bus,  b);
    endtask

    task automatic set_level(input int idx, input logic v);
        case (idx)
            0: r_cmd = v;
            1: r_dat = v;
            2: r_all = v;
            3: c_ins = v;
            4: c_rem = v;
            default: c_irq = v;
        endcase
    endtask

    task automatic set_pulse(input int idx, input logic v);
        case (idx)
            0: ev_cmd = v;
            1: ev_div = v;
            default: ev_cont = v;
        endcase
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk_all("R1 in reset", 1'b1, 1'b1, 1'b1);
        rst_n = 1'b1;
        tick();
        chk_all("R1 first edge idle", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_card_override();
        ovr_card = 1'b1;
        tick();
        chk_all("R2 card override", 1'b1, 1'b0, 1'b1);
        ovr_card = 1'b0;
        tick();
        chk_all("R2 override released", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_sys();
        xfer = 1'b1;
        tick();
        chk_all("R3 transfer", 1'b0, 1'b1, 1'b0);
        xfer = 1'b0;
        ovr_sys = 1'b1;
        tick();
        chk_all("R3 sys override", 1'b0, 1'b1, 1'b0);
        ovr_sys = 1'b0;
        r_all = 1'b1;
        tick();
        chk("R3 sys unaffected by card wake", en_sys, 1'b0);
        r_all = 1'b0;
        tick();
        chk_all("R3 idle", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_levels();
        for (int i = 0; i < 6; i++) begin
            set_level(i, 1'b1);
            tick();
            chk($sformatf("R4 level %0d card", i), en_card, 1'b1);
            chk($sformatf("R7 level %0d bus", i), en_bus, 1'b1);
            set_level(i, 1'b0);
            tick();
            chk($sformatf("R4 level %0d off card", i), en_card, 1'b0);
            chk($sformatf("R6 level %0d off bus", i), en_bus, 1'b0);
        end
    endtask

    task automatic test_pulses();
        for (int i = 0; i < 3; i++) begin
            set_pulse(i, 1'b1);
            tick();
            set_pulse(i, 1'b0);
            chk($sformatf("R5 pulse %0d cycle1", i), en_card, 1'b1);
            chk($sformatf("R7 pulse %0d cycle1 bus", i), en_bus, 1'b1);
            tick();
            chk($sformatf("R5 pulse %0d cycle2", i), en_card, 1'b1);
            chk($sformatf("R6 pulse %0d cycle2 bus", i), en_bus, 1'b1);
            tick();
            chk($sformatf("R5 pulse %0d released", i), en_card, 1'b0);
            chk($sformatf("R6 pulse %0d bus released", i), en_bus, 1'b0);
        end
    endtask

    task automatic test_bus_override();
        ovr_bus = 1'b1;
        tick();
        chk_all("R8 bus override only", 1'b0, 1'b0, 1'b1);
        ovr_bus = 1'b0;
        ovr_periph = 1'b1;
        tick();
        chk_all("R8 periph holds bus", 1'b0, 1'b0, 1'b1);
        ovr_bus = 1'b1;
        tick();
        chk("R8 both set", en_bus, 1'b1);
        ovr_bus = 1'b0;
        ovr_periph = 1'b0;
        tick();
        chk_all("R8 both clear gates bus", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic run_init(input bit restart);
        init_start = 1'b1;
        tick();
        init_start = 1'b0;
        chk("R9 init start card", en_card, 1'b1);
        for (int k = 1; k <= 80; k++) begin
            if (restart && k == 40) init_start = 1'b1;
            tick();
            init_start = 1'b0;
            if (en_card !== 1'b1 || en_bus !== 1'b1) begin
                chk($sformatf("R9 init hold k=%0d card", k), en_card, 1'b1);
                chk($sformatf("R7 init hold k=%0d bus", k), en_bus, 1'b1);
            end
        end
        n_cmp++;
        tick();
        if (restart) chk("R10 deadline unchanged", en_card, 1'b0);
        else         chk("R9 phase end", en_card, 1'b0);
        chk("R9 bus after phase", en_bus, 1'b0);
    endtask

    initial begin
        test_reset();
        test_card_override();
        test_sys();
        test_levels();
        test_pulses();
        test_bus_override();
        run_init(1'b0);
        tick();
        run_init(1'b1);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule